// File: doc/BRIEF.md
# Serial-Load Latched Segment Driver

This block drives a row of display segments from a serial bit stream. A shift clock moves bits from a serial data input into a chain of stages, one stage per rising edge. The last stage is brought out on a serial output so that several of these blocks can be chained into a longer display. A latch strobe copies the whole chain into an output latch on its rising edge. The latch is edge-triggered and is not transparent, so new data can be shifted in while the old frame stays on display.

Two override inputs shape the segment outputs. An active-low blanking input forces every segment off. An all-on test input forces every segment on. Blanking takes priority over the test input. A rising shift clock while the strobe is held high clears both the chain and the latch. This gives a one-step wipe of the whole display.

The shift clock, strobe and override inputs are synchronous logic levels sampled by the system clock `clk`. Edges of the shift clock and strobe are detected inside the block, so each input must stay at a level for at least one `clk` cycle. The serial, strobe and override pins are plain level controls with no handshake and no back-pressure: the block takes every shift edge it sees.

Top module: `serial_seg_driver`

## Requirements
- R1: After reset, every stage, every latch bit, `ser_out` and `seg_out` are 0 (with `blank_n`=1 and `lamp_test`=0).
- R2: The bit shifted in on a rising edge of `shift_clk` is the last value `ser_in` held while `shift_clk` was low. A change of `ser_in` while `shift_clk` is high has no effect. Each rise moves the stages one place from stage 1 (index 0) toward stage N (index N-1).
- R3: The latch loads the stage contents only in the `clk` cycle where a rising edge of `strobe` is seen. At all other times it holds its value, including while bits are being shifted.
- R4: `ser_out` always equals stage N (index N-1). It changes only in the cycle after a detected rise of `shift_clk`, so it is stable while `shift_clk` is low.
- R5: A rising edge of `shift_clk` seen while `strobe` is 1 clears all stages and all latch bits to 0. This clear wins over a strobe rise detected in the same cycle.
- R6: With `blank_n`=0, every bit of `seg_out` is 0, whatever the value of `lamp_test` and the latch.
- R7: With `blank_n`=1 and `lamp_test`=1, every bit of `seg_out` is 1.
- R8: With `blank_n`=1 and `lamp_test`=0, `seg_out[i]` equals latch bit i. Shifting an N-bit word in MSB first with N rises, then pulsing `strobe`, puts exactly that word on `seg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Shift clock level; a rise advances the chain |
| ser_in | input | 1 | Serial display data, sampled while `shift_clk` is low |
| strobe | input | 1 | Latch strobe level; a rise loads the latch |
| blank_n | input | 1 | Active-low blanking; 0 forces all segments off |
| lamp_test | input | 1 | All-on test; 1 forces all segments on unless blanked |
| ser_out | output | 1 | Last stage, for chaining to the next driver |
| seg_out | output | N (60) | Segment outputs |

## Verification
The hardest case to reach from the ports is the clear caused by a shift edge under a held strobe. The strobe rises first and loads the latch. Only a later shift rise inside the same high strobe pulse may wipe both the chain and the latch. The bench holds `strobe` high across a full shift-clock cycle and checks that a previously loaded word disappears from both `seg_out` and `ser_out`. The bench also flips `ser_in` during every high phase of `shift_clk`, so that sampling at the wrong time would corrupt every loaded word.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int DEF_STAGES = 60;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_ALLON = 2'd1,
    MODE_BLANK = 2'd2
  } out_mode_e;

  // blanking outranks the all-on test
  function automatic out_mode_e pick_mode(input logic blank_n, input logic lamp_test);
    if (!blank_n)       return MODE_BLANK;
    else if (lamp_test) return MODE_ALLON;
    else                return MODE_PASS;
  endfunction
endpackage

// File: rtl/ssd_edge_det.sv
module ssd_edge_det #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ssd_shift_chain.sv
module ssd_shift_chain #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_lvl,
  input  logic         ser_in,
  input  logic         adv,
  input  logic         clr,
  output logic [N-1:0] stages
);
  logic hold_bit;

  // capture the serial bit only while the shift clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_bit <= 1'b0;
    else if (!sclk_lvl) hold_bit <= ser_in;
  end

  for (genvar s = 0; s < N; s++) begin : g_stage
    logic src;
    if (s == 0) begin : g_head
      assign src = hold_bit;
    end else begin : g_body
      assign src = stages[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stages[s] <= 1'b0;
      else if (clr) stages[s] <= 1'b0;
      else if (adv) stages[s] <= src;
    end
  end
endmodule

// File: rtl/ssd_latch_bank.sv
module ssd_latch_bank #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clr,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ssd_out_gate.sv
module ssd_out_gate
  import ssd_pkg::*;
#(
  parameter int N = 60
) (
  input  out_mode_e    mode,
  input  logic [N-1:0] q,
  output logic [N-1:0] seg
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    always_comb begin
      unique case (mode)
        MODE_BLANK: seg[i] = 1'b0;
        MODE_ALLON: seg[i] = 1'b1;
        default:    seg[i] = q[i];
      endcase
    end
  end
endmodule

// File: rtl/serial_seg_driver.sv
module serial_seg_driver
  import ssd_pkg::*;
#(
  parameter int N = DEF_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_clk,
  input  logic         ser_in,
  input  logic         strobe,
  input  logic         blank_n,
  input  logic         lamp_test,
  output logic         ser_out,
  output logic [N-1:0] seg_out
);
  localparam int LAST = N - 1;

  logic         sclk_rise;
  logic         strb_rise;
  logic         wipe;
  logic         adv;
  logic [N-1:0] stages;
  logic [N-1:0] latch_q;
  out_mode_e    mode;

  // reset level 1: a line already high at release is not an edge
  ssd_edge_det #(.RST_LVL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl(shift_clk), .rise(sclk_rise)
  );
  ssd_edge_det #(.RST_LVL(1'b1)) u_strb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(strobe), .rise(strb_rise)
  );

  assign wipe = sclk_rise & strobe;
  assign adv  = sclk_rise & ~strobe;

  ssd_shift_chain #(.N(N)) u_chain (
    .clk(clk), .rst_n(rst_n), .sclk_lvl(shift_clk), .ser_in(ser_in),
    .adv(adv), .clr(wipe), .stages(stages)
  );

  ssd_latch_bank #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(strb_rise), .clr(wipe),
    .d(stages), .q(latch_q)
  );

  assign mode = pick_mode(blank_n, lamp_test);

  ssd_out_gate #(.N(N)) u_gate (
    .mode(mode), .q(latch_q), .seg(seg_out)
  );

  assign ser_out = stages[LAST];
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int N = 60
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_clk,
  input logic         strobe,
  input logic         blank_n,
  input logic         lamp_test,
  input logic         ser_out,
  input logic [N-1:0] seg_out,
  input logic [N-1:0] latch_q
);
  logic sclk_prev, strb_prev;
  logic c_rise, c_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      strb_prev <= 1'b1;
    end else begin
      sclk_prev <= shift_clk;
      strb_prev <= strobe;
    end
  end

  assign c_rise = shift_clk & ~sclk_prev;
  assign c_load = strobe & ~strb_prev;

  AST_SEROUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rise |=> $stable(ser_out)); // R4

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rise && strobe) |=> (!ser_out && latch_q == '0)); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_load && !(c_rise && strobe)) |=> $stable(latch_q)); // R3

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> seg_out == '0); // R6

  AST_TEST_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && lamp_test) |-> (&seg_out)); // R7
endmodule

bind serial_seg_driver ssd_checker #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .strobe(strobe),
  .blank_n(blank_n), .lamp_test(lamp_test), .ser_out(ser_out),
  .seg_out(seg_out), .latch_q(latch_q)
);

// File: tb/serial_seg_driver_tb_top.sv
module serial_seg_driver_tb_top;
  localparam int N = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b0, ser_in = 1'b0, strobe = 1'b0;
  logic blank_n = 1'b1, lamp_test = 1'b0;
  logic ser_out;
  logic [N-1:0] seg_out;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  serial_seg_driver #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
    .strobe(strobe), .blank_n(blank_n), .lamp_test(lamp_test),
    .ser_out(ser_out), .seg_out(seg_out)
  );

  always #4 clk = ~clk; // 125 MHz

  // behavioural reference model
  bit mq[$];
  logic [N-1:0] m_latch;
  bit m_hold, m_sclk_q, m_strb_q;

  function automatic logic [N-1:0] q2vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = mq[i];
    return v;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) mq.push_back(1'b0);
    m_latch = '0; m_hold = 0; m_sclk_q = 1; m_strb_q = 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mq[i] = 1'b0;
      m_latch = '0; m_hold = 0; m_sclk_q = 1; m_strb_q = 1;
    end else begin
      bit rs, rl;
      rs = shift_clk && !m_sclk_q;
      rl = strobe && !m_strb_q;
      if (rs && strobe) begin
        for (int i = 0; i < N; i++) mq[i] = 1'b0;
        m_latch = '0;
      end else begin
        if (rl) m_latch = q2vec();
        if (rs) begin
          void'(mq.pop_back());
          mq.push_front(m_hold);
        end
      end
      if (!shift_clk) m_hold = ser_in;
      m_sclk_q = shift_clk;
      m_strb_q = strobe;
    end
  end

  function automatic logic [N-1:0] m_seg();
    if (!blank_n) return '0;
    if (lamp_test) return '1;
    return m_latch;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (seg_out !== m_seg()) begin
        fails++;
        $display("FAIL R8 model seg_out act=%h exp=%h", seg_out, m_seg());
      end
      checks++;
      if (ser_out !== mq[N-1]) begin
        fails++;
        $display("FAIL R4 model ser_out act=%b exp=%b", ser_out, mq[N-1]);
      end
    end
  end

  task automatic chk_seg(input string req, input logic [N-1:0] exp);
    checks++;
    if (seg_out !== exp) begin
      fails++;
      $display("FAIL %s seg_out act=%h exp=%h", req, seg_out, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic exp);
    checks++;
    if (ser_out !== exp) begin
      fails++;
      $display("FAIL %s ser_out act=%b exp=%b", req, ser_out, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ser_in is flipped during the high phase; it must be ignored (R2)
  task automatic shift_bit(input logic b);
    shift_clk = 1'b0; ser_in = b; cyc(2);
    shift_clk = 1'b1; cyc(1);
    ser_in = ~b; cyc(1);
  endtask

  task automatic load_word(input logic [N-1:0] w);
    for (int k = N - 1; k >= 0; k--) shift_bit(w[k]);
    shift_clk = 1'b0; cyc(1);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; cyc(2);
    strobe = 1'b0; cyc(2);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      summary();
    end
  end

  logic [N-1:0] w1, w2;

  initial begin
    w1 = 60'hA5C3F019E27D4B6;
    w2 = 60'h3B1E8C77059DA42;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk_seg("R1", '0);
    chk_bit("R1", 1'b0);

    // main function
    load_word(w1);
    chk_seg("R3", '0);             // no strobe yet, latch still empty
    chk_bit("R4", w1[N-1]);        // first bit sent sits in the last stage
    pulse_strobe();
    chk_seg("R8", w1);
    chk_seg("R2", w1);

    // one more shift: last stage now holds the second bit sent
    shift_bit(1'b0); shift_clk = 1'b0; cyc(1);
    chk_bit("R4", w1[N-2]);
    chk_seg("R3", w1);

    // overrides
    blank_n = 1'b0; cyc(1);
    chk_seg("R6", '0);
    lamp_test = 1'b1; cyc(1);
    chk_seg("R6", '0);
    blank_n = 1'b1; cyc(1);
    chk_seg("R7", '1);
    lamp_test = 1'b0; cyc(1);
    chk_seg("R8", w1);

    // new word shifted under a held latch
    load_word(w2);
    chk_seg("R3", w1);
    pulse_strobe();
    chk_seg("R8", w2);

    // random words
    for (int r = 0; r < 6; r++) begin
      logic [N-1:0] wr;
      wr = {$urandom(), $urandom()};
      load_word(wr);
      pulse_strobe();
      chk_seg("R8", wr);
    end

    // clear by a shift edge under a held strobe
    load_word(w1);
    strobe = 1'b1; cyc(2);
    chk_seg("R3", w1);
    shift_clk = 1'b1; cyc(2);
    chk_seg("R5", '0);
    chk_bit("R5", 1'b0);
    shift_clk = 1'b0; strobe = 1'b0; cyc(2);
    pulse_strobe();
    chk_seg("R5", '0);

    // simultaneous rise of strobe and shift clock: the clear wins
    load_word(w2);
    pulse_strobe();
    chk_seg("R8", w2);
    strobe = 1'b1; shift_clk = 1'b1; cyc(2);
    chk_seg("R5", '0);
    chk_bit("R5", 1'b0);
    strobe = 1'b0; shift_clk = 1'b0; cyc(2);

    // reset returns everything to zero
    load_word(w1);
    pulse_strobe();
    rst_n = 1'b0; cyc(2);
    rst_n = 1'b1; cyc(2);
    chk_seg("R1", '0);
    chk_bit("R1", 1'b0);

    summary();
  end
endmodule